// File: doc/BRIEF.md
# Daylight Saving Time Adjuster

This block sits beside a running BCD calendar and decides when the clock must jump for daylight saving time. It holds two rules, one for the start of summer time and one for its end. Each rule names a month and an hour. It also names either a fixed day of the month or a weekday together with its week within the month. The week can be "last" to mean the final occurrence of that weekday. The calendar presents the current month, date, weekday, hour, minute and second together with a one-cycle tick each time it advances. When a rule matches, the block issues a one-cycle command telling the calendar to move its hour one step forward or one step back.

A status flag shows that the forward change has been applied and summer time is in effect. The backward change is taken only while the flag is set, and taking it clears the flag. So when the calendar repeats the same hour after stepping back, no second backward change is issued. A global enable turns the whole function on or off. Dropping the enable also clears the flag. Leap-year determination is left to the calendar, which supplies it as an input.

Top module: `dst_adjust`

## Requirements
- R1: While reset is held and in the first cycle after it, `hour_fwd`, `hour_back` and `dst_active` are all 0.
- R2: In a fixed-date rule (week field 0), the forward rule matches when month, date and hour equal the current BCD values. The weekday is ignored. On a match with `dst_active` clear, `hour_fwd` is 1 in the cycle after the tick and `dst_active` becomes 1 at the same edge.
- R3: A rule is evaluated only in a cycle where `tick` is 1, `cur_min` is 8'h00 and `cur_sec` is 8'h00. Any other minute or second value, or a missing tick, gives no command.
- R4: While `dst_en` is 0, no command is issued and `dst_active` is cleared one cycle later.
- R5: A week field of 1 to 5 matches when the weekday code (0 to 6, compared as a plain value) equals `cur_dow` and the week of the month, computed as (date-1)/7+1, equals the week field.
- R6: A week field of 7 matches the weekday when date+7 exceeds the month length. The month length is 31, 30 or 28 by month, and February has 29 when `leap_year` is 1.
- R7: The reverse rule yields `hour_back` only while `dst_active` is 1, and clears `dst_active` at the same edge. A repeated reverse point afterwards gives no command.
- R8: While `dst_active` is 1, a forward match gives no command.
- R9: A week field of 6 never matches.
- R10: Each command lasts exactly one cycle, and `hour_fwd` and `hour_back` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dst_en | input | 1 | Global enable for the adjuster |
| leap_year | input | 1 | Current year is a leap year |
| fwd_month | input | 5 | Forward rule month, BCD 01-12 |
| fwd_week | input | 3 | Forward rule week: 0 date, 1-5 nth, 7 last |
| fwd_dow | input | 3 | Forward rule weekday, 0-6 |
| fwd_date | input | 6 | Forward rule date, BCD 01-31 |
| fwd_hour | input | 6 | Forward rule hour, BCD 00-23 |
| rev_month | input | 5 | Reverse rule month, BCD |
| rev_week | input | 3 | Reverse rule week selector |
| rev_dow | input | 3 | Reverse rule weekday |
| rev_date | input | 6 | Reverse rule date, BCD |
| rev_hour | input | 6 | Reverse rule hour, BCD |
| tick | input | 1 | Calendar advanced this cycle |
| cur_month | input | 5 | Current month, BCD |
| cur_date | input | 6 | Current date, BCD |
| cur_dow | input | 3 | Current weekday, 0-6 |
| cur_hour | input | 6 | Current hour, BCD 24-hour |
| cur_min | input | 7 | Current minute, BCD |
| cur_sec | input | 7 | Current second, BCD |
| hour_fwd | output | 1 | One-cycle command: advance hour by one |
| hour_back | output | 1 | One-cycle command: retard hour by one |
| dst_active | output | 1 | Forward change applied, summer time in effect |

## Verification
Several properties are checked on every cycle:
- the two commands are exclusive and last one cycle;
- a command always follows a tick on a whole hour;
- the forward command coincides with the flag rising, and the backward command with it falling;
- a set flag blocks the forward command;
- a cleared enable silences everything.

Whether a rule matches the right day cannot be seen by a property, because that depends on the calendar arithmetic. The bench scenarios cover it: fixed dates, the nth-weekday edges at dates 7, 8, 14 and 15, last-weekday edges in 31-, 30- and 28/29-day months, and the never-matching week code.

// File: rtl/dst_pkg.sv
// Package: shared widths, the rule record and BCD helpers for the
// daylight-saving adjuster. Assumes all calendar fields are packed BCD.
package dst_pkg;

    localparam int MON_W   = 5;
    localparam int DATE_W  = 6;
    localparam int HOUR_W  = 6;
    localparam int MS_W    = 7;
    localparam int DOW_W   = 3;
    localparam int WEEK_W  = 3;
    localparam int BIN_W   = 8;
    localparam int DAYS_W  = 5;
    localparam int NRULES  = 2;

    localparam logic [WEEK_W-1:0] WK_FIXED = 3'd0;
    localparam logic [WEEK_W-1:0] WK_LAST  = 3'd7;

    typedef struct packed {
        logic [MON_W-1:0]  month;
        logic [WEEK_W-1:0] week;
        logic [DOW_W-1:0]  dow;
        logic [DATE_W-1:0] date;
        logic [HOUR_W-1:0] hour;
    } dst_rule_t;

    // Convert a packed BCD byte to binary.
    function automatic logic [BIN_W-1:0] bcd_to_bin(input logic [BIN_W-1:0] v);
        return BIN_W'(v[7:4]) * BIN_W'(10) + BIN_W'(v[3:0]);
    endfunction

endpackage

// File: rtl/dst_month_len.sv
// Module: returns the number of days in a month.
// Assumes a binary month 1..12; leap-year status is supplied from outside.
module dst_month_len
    import dst_pkg::*;
(
    input  logic [BIN_W-1:0]  month_bin,
    input  logic              leap_year,
    output logic [DAYS_W-1:0] days
);

    // Pick 28/29, 30 or 31 from the month number.
    always_comb begin
        unique case (month_bin)
            8'd2:                      days = leap_year ? 5'd29 : 5'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   days = 5'd30;
            default:                   days = 5'd31;
        endcase
    end

endmodule

// File: rtl/dst_week_pos.sv
// Module: finds where a date falls within its month. The outputs are the
// week ordinal (date-1)/7+1 and whether the date lies in the final seven
// days. Assumes a binary date 1..31.
module dst_week_pos
    import dst_pkg::*;
(
    input  logic [BIN_W-1:0]  date_bin,
    input  logic [DAYS_W-1:0] days,
    output logic [WEEK_W-1:0] week_idx,
    output logic              in_last
);

    // Ordinal week of the month by threshold compare (no divider).
    always_comb begin
        if      (date_bin <= 8'd7)  week_idx = 3'd1;
        else if (date_bin <= 8'd14) week_idx = 3'd2;
        else if (date_bin <= 8'd21) week_idx = 3'd3;
        else if (date_bin <= 8'd28) week_idx = 3'd4;
        else                        week_idx = 3'd5;
    end

    // Last occurrence: one more week would run past the month end.
    always_comb in_last = (date_bin + 8'd7) > BIN_W'(days);

endmodule

// File: rtl/dst_rule_match.sv
// Module: compares one daylight-saving rule against the current calendar.
// Assumes week position and last-week flag are precomputed for today.
module dst_rule_match
    import dst_pkg::*;
(
    input  dst_rule_t         rule,
    input  logic [MON_W-1:0]  cur_month,
    input  logic [DATE_W-1:0] cur_date,
    input  logic [DOW_W-1:0]  cur_dow,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [WEEK_W-1:0] week_idx,
    input  logic              in_last,
    output logic              hit
);

    logic mh_ok;
    logic day_ok;

    // Month and hour must match for every rule kind.
    always_comb mh_ok = (rule.month == cur_month) && (rule.hour == cur_hour);

    // Day selection: fixed date, nth weekday, last weekday; 6 never matches.
    always_comb begin
        if (rule.week == WK_FIXED)
            day_ok = (rule.date == cur_date);
        else if (rule.week == WK_LAST)
            day_ok = (rule.dow == cur_dow) && in_last;
        else if (rule.week <= 3'd5)
            day_ok = (rule.dow == cur_dow) && (rule.week == week_idx);
        else
            day_ok = 1'b0;
    end

    // Combined rule hit.
    always_comb hit = mh_ok && day_ok;

endmodule

// File: rtl/dst_adjust.sv
// Module: daylight-saving adjuster top. Evaluates the forward and reverse
// rules on each calendar tick at a whole hour. It issues one-cycle hour
// step commands and keeps the summer-time flag. Assumes the calendar
// applies the step itself and supplies BCD fields.
module dst_adjust
    import dst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dst_en,
    input  logic              leap_year,
    input  logic [MON_W-1:0]  fwd_month,
    input  logic [WEEK_W-1:0] fwd_week,
    input  logic [DOW_W-1:0]  fwd_dow,
    input  logic [DATE_W-1:0] fwd_date,
    input  logic [HOUR_W-1:0] fwd_hour,
    input  logic [MON_W-1:0]  rev_month,
    input  logic [WEEK_W-1:0] rev_week,
    input  logic [DOW_W-1:0]  rev_dow,
    input  logic [DATE_W-1:0] rev_date,
    input  logic [HOUR_W-1:0] rev_hour,
    input  logic              tick,
    input  logic [MON_W-1:0]  cur_month,
    input  logic [DATE_W-1:0] cur_date,
    input  logic [DOW_W-1:0]  cur_dow,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [MS_W-1:0]   cur_min,
    input  logic [MS_W-1:0]   cur_sec,
    output logic              hour_fwd,
    output logic              hour_back,
    output logic              dst_active
);

    localparam int RULE_FWD = 0;
    localparam int RULE_REV = NRULES - 1;

    dst_rule_t          rules [NRULES];
    logic [NRULES-1:0]  hits;
    logic [BIN_W-1:0]   month_bin;
    logic [BIN_W-1:0]   date_bin;
    logic [DAYS_W-1:0]  days;
    logic [WEEK_W-1:0]  week_idx;
    logic               in_last;
    logic               on_hour;

    // Gather rule fields into the indexed rule array.
    always_comb begin
        rules[RULE_FWD] = '{month: fwd_month, week: fwd_week, dow: fwd_dow,
                            date: fwd_date, hour: fwd_hour};
        rules[RULE_REV] = '{month: rev_month, week: rev_week, dow: rev_dow,
                            date: rev_date, hour: rev_hour};
    end

    // Binary forms of month and date for the calendar arithmetic.
    always_comb begin
        month_bin = bcd_to_bin(BIN_W'(cur_month));
        date_bin  = bcd_to_bin(BIN_W'(cur_date));
    end

    dst_month_len u_mlen (
        .month_bin (month_bin),
        .leap_year (leap_year),
        .days      (days)
    );

    dst_week_pos u_wpos (
        .date_bin (date_bin),
        .days     (days),
        .week_idx (week_idx),
        .in_last  (in_last)
    );

    for (genvar g = 0; g < NRULES; g++) begin : g_rule
        dst_rule_match u_match (
            .rule      (rules[g]),
            .cur_month (cur_month),
            .cur_date  (cur_date),
            .cur_dow   (cur_dow),
            .cur_hour  (cur_hour),
            .week_idx  (week_idx),
            .in_last   (in_last),
            .hit       (hits[g])
        );
    end

    // Evaluation window: a tick landing on minute 00, second 00.
    always_comb on_hour = tick && (cur_min == '0) && (cur_sec == '0);

    // Command pulses and summer-time flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hour_fwd   <= 1'b0;
            hour_back  <= 1'b0;
            dst_active <= 1'b0;
        end else begin
            hour_fwd  <= 1'b0;
            hour_back <= 1'b0;
            if (!dst_en) begin
                dst_active <= 1'b0;
            end else if (on_hour) begin
                if (hits[RULE_FWD] && !dst_active) begin
                    hour_fwd   <= 1'b1;
                    dst_active <= 1'b1;
                end else if (hits[RULE_REV] && dst_active) begin
                    hour_back  <= 1'b1;
                    dst_active <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/dst_adjust_chk.sv
// Checker: temporal properties of the adjuster's commands and flag.
module dst_adjust_chk
    import dst_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             dst_en,
    input logic             tick,
    input logic [MS_W-1:0]  cur_min,
    input logic [MS_W-1:0]  cur_sec,
    input logic             hour_fwd,
    input logic             hour_back,
    input logic             dst_active
);

    a_r2_fwd_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
        hour_fwd |-> dst_active);

    a_r2_rise_needs_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dst_active) |-> hour_fwd);

    a_r3_only_on_hour: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_fwd || hour_back) |-> $past(tick && cur_min == '0 && cur_sec == '0));

    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!dst_en) |-> (!hour_fwd && !hour_back && !dst_active));

    a_r7_back_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hour_back |-> (!dst_active && $past(dst_active)));

    a_r8_no_fwd_active: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dst_active) |-> !hour_fwd);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hour_fwd && hour_back));

    a_r10_fwd_single: assert property (@(posedge clk) disable iff (!rst_n)
        hour_fwd |=> !hour_fwd);

    a_r10_back_single: assert property (@(posedge clk) disable iff (!rst_n)
        hour_back |=> !hour_back);

endmodule

bind dst_adjust dst_adjust_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dst_en     (dst_en),
    .tick       (tick),
    .cur_min    (cur_min),
    .cur_sec    (cur_sec),
    .hour_fwd   (hour_fwd),
    .hour_back  (hour_back),
    .dst_active (dst_active)
);

// File: tb/dst_adjust_tb.sv
// Bench: directed scenarios for the daylight-saving adjuster.
module dst_adjust_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dst_en = 1'b0;
    logic       leap_year = 1'b0;
    logic [4:0] fwd_month = '0, rev_month = '0, cur_month = 5'h01;
    logic [2:0] fwd_week = '0, rev_week = '0, fwd_dow = '0, rev_dow = '0, cur_dow = '0;
    logic [5:0] fwd_date = '0, rev_date = '0, cur_date = 6'h01;
    logic [5:0] fwd_hour = '0, rev_hour = '0, cur_hour = '0;
    logic [6:0] cur_min = 7'h30, cur_sec = 7'h30;
    logic       tick = 1'b0;
    logic       hour_fwd, hour_back, dst_active;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dst_adjust u_dut (
        .clk(clk), .rst_n(rst_n), .dst_en(dst_en), .leap_year(leap_year),
        .fwd_month(fwd_month), .fwd_week(fwd_week), .fwd_dow(fwd_dow),
        .fwd_date(fwd_date), .fwd_hour(fwd_hour),
        .rev_month(rev_month), .rev_week(rev_week), .rev_dow(rev_dow),
        .rev_date(rev_date), .rev_hour(rev_hour),
        .tick(tick), .cur_month(cur_month), .cur_date(cur_date),
        .cur_dow(cur_dow), .cur_hour(cur_hour), .cur_min(cur_min),
        .cur_sec(cur_sec), .hour_fwd(hour_fwd), .hour_back(hour_back),
        .dst_active(dst_active)
    );

    task automatic check(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Present one calendar state with or without tick and check the response.
    task automatic step(string req, logic [4:0] mo, logic [5:0] dt, logic [2:0] dw,
                        logic [5:0] hr, logic [6:0] mi, logic [6:0] se, logic tk,
                        logic ef, logic eb, logic ea);
        @(negedge clk);
        cur_month = mo; cur_date = dt; cur_dow = dw; cur_hour = hr;
        cur_min = mi; cur_sec = se; tick = tk;
        @(negedge clk);
        tick = 1'b0;
        check(req, "hour_fwd", hour_fwd, ef);
        check(req, "hour_back", hour_back, eb);
        check(req, "dst_active", dst_active, ea);
        @(negedge clk);
        check("R10", "fwd pulse ends", hour_fwd, 1'b0);
        check("R10", "back pulse ends", hour_back, 1'b0);
    endtask

    task automatic clear_flag();
        @(negedge clk); dst_en = 1'b0;
        @(negedge clk); dst_en = 1'b1;
    endtask

    task automatic set_fwd(logic [4:0] mo, logic [2:0] wk, logic [2:0] dw,
                           logic [5:0] dt, logic [5:0] hr);
        fwd_month = mo; fwd_week = wk; fwd_dow = dw; fwd_date = dt; fwd_hour = hr;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "fwd in reset", hour_fwd, 1'b0);
        check("R1", "back in reset", hour_back, 1'b0);
        check("R1", "active in reset", dst_active, 1'b0);
        rst_n = 1'b1; dst_en = 1'b1;
        @(negedge clk);
        check("R1", "active after reset", dst_active, 1'b0);
    endtask

    task automatic t_fixed();
        step("R2", 5'h03, 6'h10, 3'd3, 6'h02, 7'h00, 7'h00, 1'b1, 1, 0, 1);
        step("R8", 5'h03, 6'h10, 3'd3, 6'h02, 7'h00, 7'h00, 1'b1, 0, 0, 1);
    endtask

    task automatic t_reverse();
        step("R7", 5'h11, 6'h03, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 0, 1, 0);
        step("R7", 5'h11, 6'h03, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 0, 0, 0);
    endtask

    task automatic t_gate();
        step("R3", 5'h03, 6'h10, 3'd3, 6'h02, 7'h01, 7'h00, 1'b1, 0, 0, 0);
        step("R3", 5'h03, 6'h10, 3'd3, 6'h02, 7'h00, 7'h01, 1'b1, 0, 0, 0);
        step("R3", 5'h03, 6'h10, 3'd3, 6'h02, 7'h00, 7'h00, 1'b0, 0, 0, 0);
        step("R2", 5'h03, 6'h10, 3'd3, 6'h03, 7'h00, 7'h00, 1'b1, 0, 0, 0);
        step("R2", 5'h03, 6'h11, 3'd3, 6'h02, 7'h00, 7'h00, 1'b1, 0, 0, 0);
    endtask

    task automatic t_disable();
        step("R4", 5'h03, 6'h10, 3'd3, 6'h02, 7'h00, 7'h00, 1'b1, 1, 0, 1);
        @(negedge clk); dst_en = 1'b0;
        @(negedge clk);
        check("R4", "flag cleared by disable", dst_active, 1'b0);
        step("R4", 5'h03, 6'h10, 3'd3, 6'h02, 7'h00, 7'h00, 1'b1, 0, 0, 0);
        @(negedge clk); dst_en = 1'b1;
    endtask

    task automatic t_nth();
        set_fwd(5'h03, 3'd2, 3'd0, 6'h01, 6'h02);
        step("R5", 5'h03, 6'h08, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 1, 0, 1);
        clear_flag();
        step("R5", 5'h03, 6'h14, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 1, 0, 1);
        clear_flag();
        step("R5", 5'h03, 6'h15, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 0, 0, 0);
        step("R5", 5'h03, 6'h07, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 0, 0, 0);
        step("R5", 5'h03, 6'h08, 3'd1, 6'h02, 7'h00, 7'h00, 1'b1, 0, 0, 0);
    endtask

    task automatic t_last();
        set_fwd(5'h10, 3'd7, 3'd0, 6'h01, 6'h02);
        step("R6", 5'h10, 6'h25, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 1, 0, 1);
        clear_flag();
        step("R6", 5'h10, 6'h24, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 0, 0, 0);
        set_fwd(5'h04, 3'd7, 3'd0, 6'h01, 6'h02);
        step("R6", 5'h04, 6'h23, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 0, 0, 0);
        step("R6", 5'h04, 6'h24, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 1, 0, 1);
        clear_flag();
        set_fwd(5'h02, 3'd7, 3'd0, 6'h01, 6'h02);
        leap_year = 1'b0;
        step("R6", 5'h02, 6'h21, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 0, 0, 0);
        step("R6", 5'h02, 6'h22, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 1, 0, 1);
        clear_flag();
        leap_year = 1'b1;
        step("R6", 5'h02, 6'h22, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 0, 0, 0);
        step("R6", 5'h02, 6'h23, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 1, 0, 1);
        clear_flag();
        leap_year = 1'b0;
    endtask

    task automatic t_week6();
        set_fwd(5'h03, 3'd6, 3'd0, 6'h29, 6'h02);
        step("R9", 5'h03, 6'h29, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 0, 0, 0);
        step("R9", 5'h03, 6'h31, 3'd0, 6'h02, 7'h00, 7'h00, 1'b1, 0, 0, 0);
    endtask

    initial begin
        set_fwd(5'h03, 3'd0, 3'd0, 6'h10, 6'h02);
        rev_month = 5'h11; rev_week = 3'd0; rev_dow = 3'd0;
        rev_date = 6'h03; rev_hour = 6'h02;
        t_reset();
        t_fixed();
        t_reverse();
        t_gate();
        t_disable();
        t_nth();
        t_last();
        t_week6();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule